// File: doc/BRIEF.md
# Serial ADC Host Interface Controller

This block is the host-side master for a multichannel serial converter that returns a 13-bit result, made of a sign bit and twelve data bits, tagged with a channel number. Each request from the user side starts one frame. In that frame the block lowers chip select and waits a setup interval. It then runs sixteen serial clock periods. During those periods it shifts the 16-bit request word out on the data-in line and collects the 16-bit result word from the data-out line. After the last period it raises chip select and holds it high for a quiet interval before the next frame can start.

The serial clock is made from the system clock by a counter. Each half period lasts a fixed number of system clocks, and the serial clock rests high whenever chip select is high. Data-in changes only on rising serial clock edges, so it is steady across every falling edge, where the converter samples it. Each returned bit is taken in on the system clock edge that produces a falling serial clock edge. By that point the bit has been stable for a full serial period.

When a frame ends, the block splits the collected word. The top three bits become the channel number, and the lower thirteen bits are treated as a two's-complement value and sign-extended to the sample width. Both are presented with a one-cycle valid pulse. While a frame and its quiet gap are in progress, the block reports itself busy and holds off new requests.

Top module: `adc_serial_host`

## Requirements
- R1: After reset, chip select and the serial clock are high, busy and rsp_valid are low, and req_ready is high.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. From the next cycle, busy is high and req_ready is low, until the quiet interval has ended.
- R3: Chip select falls in the cycle after acceptance. The first falling serial clock edge comes exactly SETUP_CYC system clocks after chip select falls.
- R4: Each frame holds exactly 16 falling serial clock edges. Every low phase and every high phase between them lasts exactly HALF_CYC system clocks.
- R5: The serial clock is high in every cycle in which chip select is high.
- R6: Data-in carries the request word MSB first, with bit 15 at the first falling edge. Its value does not change in the cycle of any falling serial clock edge.
- R7: A request word whose bit 15 (the write-enable bit) is 0 is still clocked out in full: 16 falling edges, all 16 bits on data-in.
- R8: Data-out is sampled once per falling serial clock edge, MSB first, to build a 16-bit result word.
- R9: rsp_valid is high for exactly one cycle, the first cycle in which chip select is high again. In that cycle rsp_chan equals result bits 15:13, and rsp_sample equals result bits 12:0 read as two's complement and sign-extended.
- R10: Chip select stays high for at least QUIET_CYC system clocks between frames. A request held waiting is started as soon as the quiet interval ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request word is offered |
| req_ready | output | 1 | Block can take a request this cycle |
| req_word | input | 16 | Control word sent during the frame |
| busy | output | 1 | Frame or quiet gap in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_chan | output | 3 | Channel number from the result |
| rsp_sample | output | 16 | Sign-extended sample |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, rests high |
| din | output | 1 | Serial data toward the converter |
| dout | input | 1 | Serial data from the converter |

## Verification
If the bit counter is off by one, the frame ends with the wrong number of falling edges. The very next rise of chip select then shows a corrupted channel or sample, or a short data-in word. A wrong phase counter load stretches or shrinks a half period, which is visible at the next serial clock edge. A state machine that leaves the quiet state too early shows a short chip-select high gap at the next falling edge of chip select. A wrong sign-extension or field split appears in the first response whose sign bit is set.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_QUIET
  } ash_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ash_tick.sv
module ash_tick #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ash_shift.sv
module ash_shift #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] load_word,
  input  logic         adv,
  input  logic         cap,
  input  logic         cap_bit,
  output logic         tx_msb,
  output logic [N-1:0] rx_word
);
  logic [N-1:0] tx_q;
  logic [N-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst)       tx_q <= '0;
    else if (load) tx_q <= load_word;
    else if (adv)  tx_q <= {tx_q[N-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)      rx_q <= '0;
    else if (cap) rx_q <= {rx_q[N-2:0], cap_bit};
  end

  assign tx_msb  = tx_q[N-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/ash_ctrl.sv
module ash_ctrl
  import adc_host_pkg::*;
#(
  parameter int N         = 16,
  parameter int HALF_CYC  = 2,
  parameter int SETUP_CYC = 3,
  parameter int QUIET_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  output logic req_ready,
  output logic busy,
  output logic cs_n,
  output logic sclk,
  output logic ld_word,
  output logic adv,
  output logic cap,
  output logic frame_done
);
  localparam int MAXV = max3(HALF_CYC, SETUP_CYC, QUIET_CYC);
  localparam int TW   = $clog2(MAXV + 1);
  localparam int BW   = $clog2(N);

  ash_state_e      state_q;
  logic            cs_n_q, sclk_q;
  logic [BW-1:0]   bit_q;
  logic            tick_load, tick_zero;
  logic [TW-1:0]   tick_val;
  logic            accept, last, fall_now, rise_now, done_now, quiet_end;

  ash_tick #(.W(TW)) u_tick (
    .clk(clk), .rst(rst), .load(tick_load), .load_val(tick_val), .zero(tick_zero)
  );

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign last      = (bit_q == BW'(N - 1));
  assign fall_now  = tick_zero && ((state_q == ST_SETUP) || ((state_q == ST_HIGH) && !last));
  assign rise_now  = tick_zero && (state_q == ST_LOW);
  assign done_now  = tick_zero && (state_q == ST_HIGH) && last;
  assign quiet_end = tick_zero && (state_q == ST_QUIET);

  always_comb begin
    tick_load = accept || fall_now || rise_now || done_now;
    if (accept)        tick_val = TW'(SETUP_CYC - 1);
    else if (done_now) tick_val = TW'(QUIET_CYC - 1);
    else               tick_val = TW'(HALF_CYC - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b1;
      bit_q   <= '0;
    end else begin
      if (accept) begin
        state_q <= ST_SETUP;
        cs_n_q  <= 1'b0;
        bit_q   <= '0;
      end
      if (fall_now) begin
        state_q <= ST_LOW;
        sclk_q  <= 1'b0;
        if (state_q == ST_HIGH) bit_q <= bit_q + 1'b1;
      end
      if (rise_now) begin
        state_q <= ST_HIGH;
        sclk_q  <= 1'b1;
      end
      if (done_now) begin
        state_q <= ST_QUIET;
        cs_n_q  <= 1'b1;
      end
      if (quiet_end) state_q <= ST_IDLE;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign busy       = (state_q != ST_IDLE);
  assign cs_n       = cs_n_q;
  assign sclk       = sclk_q;
  assign ld_word    = accept;
  assign adv        = rise_now && !last;
  assign cap        = fall_now;
  assign frame_done = done_now;

  // gap watcher for the quiet-interval rule
  logic [TW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst)                         gap_q <= TW'(QUIET_CYC);
    else if (!cs_n_q)                gap_q <= '0;
    else if (gap_q < TW'(QUIET_CYC)) gap_q <= gap_q + 1'b1;
  end

  AST_SCLK_REST_HIGH: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk); // R5
  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid)); // R2
  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (gap_q >= TW'(QUIET_CYC))); // R10
  AST_CS_BEFORE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> sclk); // R3
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host #(
  parameter int ID_W      = 3,
  parameter int CODE_W    = 13,
  parameter int SAMPLE_W  = 16,
  parameter int HALF_CYC  = 2,
  parameter int SETUP_CYC = 3,
  parameter int QUIET_CYC = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ID_W+CODE_W-1:0]     req_word,
  output logic                       busy,
  output logic                       rsp_valid,
  output logic [ID_W-1:0]            rsp_chan,
  output logic [SAMPLE_W-1:0]        rsp_sample,
  output logic                       cs_n,
  output logic                       sclk,
  output logic                       din,
  input  logic                       dout
);
  localparam int FRAME_W = ID_W + CODE_W;
  localparam int EXT_W   = SAMPLE_W - CODE_W;

  logic               ld_word, adv, cap, frame_done;
  logic [FRAME_W-1:0] rx_word;

  ash_ctrl #(
    .N(FRAME_W), .HALF_CYC(HALF_CYC), .SETUP_CYC(SETUP_CYC), .QUIET_CYC(QUIET_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .busy(busy), .cs_n(cs_n), .sclk(sclk), .ld_word(ld_word), .adv(adv),
    .cap(cap), .frame_done(frame_done)
  );

  ash_shift #(.N(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .load(ld_word), .load_word(req_word), .adv(adv),
    .cap(cap), .cap_bit(dout), .tx_msb(din), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_chan   <= '0;
      rsp_sample <= '0;
    end else begin
      rsp_valid <= frame_done;
      if (frame_done) begin
        rsp_chan   <= rx_word[FRAME_W-1:CODE_W];
        rsp_sample <= {{EXT_W{rx_word[CODE_W-1]}}, rx_word[CODE_W-1:0]};
      end
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R9
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (cs_n && $rose(cs_n))); // R9
  AST_DIN_STEADY_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> $stable(din)); // R6
endmodule

// File: tb/sim_adc_serial_host.sv
module sim_adc_serial_host;
  localparam int HALF  = 2;
  localparam int SETUP = 3;
  localparam int QUIET = 5;
  localparam int NFR   = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_word = '0;
  logic        req_ready, busy, rsp_valid, cs_n, sclk, din;
  logic [2:0]  rsp_chan;
  logic [15:0] rsp_sample;
  logic        dout = 1'b0;

  adc_serial_host #(.HALF_CYC(HALF), .SETUP_CYC(SETUP), .QUIET_CYC(QUIET)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .busy(busy), .rsp_valid(rsp_valid), .rsp_chan(rsp_chan),
    .rsp_sample(rsp_sample), .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  logic [15:0] req_w [NFR];
  logic [15:0] rsp_w [NFR];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_sample(input logic [15:0] w);
    return {{3{w[12]}}, w[12:0]};
  endfunction

  // converter model
  int          dev_fr = 0;
  int          dev_idx = 0;
  logic [15:0] dev_rsp = '0;
  always @(negedge cs_n) begin
    dev_rsp = rsp_w[dev_fr % NFR];
    dev_fr++;
    dev_idx = 0;
    dout <= dev_rsp[15];
  end
  always @(negedge sclk) begin
    if (!cs_n) begin
      dev_idx++;
      dout <= (dev_idx < 16) ? dev_rsp[15 - dev_idx] : 1'b0;
    end
  end

  // acceptance counter
  int acc_cnt = 0;
  always @(posedge clk) if (!rst && req_valid && req_ready) acc_cnt++;

  // port monitor
  int   cyc = 0, cs_fall_c = 0, cs_rise_c = -100, fall_c = 0, rise_c = 0, nfall = 0, fr_mon = 0;
  logic cs_prev = 1'b1, sclk_prev = 1'b1, din_prev = 1'b0, seen_rise = 1'b0;
  logic [15:0] din_got = '0;
  bit   done_flag = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (cs_n && !sclk) check(0, "R5 sclk low while cs high", 0, 1);
      if (cs_prev && !cs_n) begin
        if (seen_rise) check((cyc - cs_rise_c) >= QUIET, "R10 quiet gap", cyc - cs_rise_c, QUIET);
        cs_fall_c = cyc; nfall = 0; din_got = '0;
      end
      if (sclk_prev && !sclk && !cs_n) begin
        if (nfall == 0) check((cyc - cs_fall_c) == SETUP, "R3 setup", cyc - cs_fall_c, SETUP);
        else check((cyc - rise_c) == HALF, "R4 high phase", cyc - rise_c, HALF);
        check(din == din_prev, "R6 din moved at fall", din, din_prev);
        din_got = {din_got[14:0], din};
        nfall++; fall_c = cyc;
      end
      if (!sclk_prev && sclk && !cs_n) begin
        check((cyc - fall_c) == HALF, "R4 low phase", cyc - fall_c, HALF);
        rise_c = cyc;
      end
      if (rsp_valid && !(!cs_prev && cs_n)) check(0, "R9 stray valid", 1, 0);
      if (!cs_prev && cs_n) begin
        seen_rise = 1'b1; cs_rise_c = cyc;
        check(nfall == 16, req_w[fr_mon][15] ? "R4 edge count" : "R7 edge count (WE=0)", nfall, 16);
        check(din_got == req_w[fr_mon], req_w[fr_mon][15] ? "R6 din word" : "R7 din word (WE=0)",
              din_got, req_w[fr_mon]);
        check(rsp_valid == 1'b1, "R9 valid at cs rise", rsp_valid, 1);
        check(rsp_chan == rsp_w[fr_mon][15:13], "R9 channel", rsp_chan, rsp_w[fr_mon][15:13]);
        check(rsp_sample == exp_sample(rsp_w[fr_mon]), "R8 sample", rsp_sample, exp_sample(rsp_w[fr_mon]));
        fr_mon++;
      end
    end
    cs_prev = cs_n; sclk_prev = sclk; din_prev = din;
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1;
      check(0, "watchdog", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NFR; i++) begin
      req_w[i] = 16'($urandom);
      rsp_w[i] = 16'($urandom);
    end
    rsp_w[0] = 16'hF000;                       // chan 7, most negative
    rsp_w[1] = 16'h0FFF;                       // chan 0, most positive
    req_w[2] = 16'h7FFF;                       // write-enable clear
    req_w[3] = 16'h0000; rsp_w[3] = 16'hFFFF;  // WE clear, sample -1
    req_w[4] = 16'hFFFF; rsp_w[4] = 16'h1000;  // zero sign bit only

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    check(sclk == 1'b1, "R1 sclk", sclk, 1);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);

    for (int n = 0; n < NFR; n++) begin
      req_valid = 1'b1;
      req_word  = req_w[n];
      do @(negedge clk); while (acc_cnt != n + 1);
      check(busy == 1'b1 && req_ready == 1'b0, "R2 busy after accept", {busy, req_ready}, 2);
      check(cs_n == 1'b0, "R3 cs falls after accept", cs_n, 0);
      if ((n % 3) == 0) begin
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat ($urandom_range(0, 4)) @(negedge clk);
      end else if (n + 1 < NFR) begin
        req_word = req_w[n + 1];  // back-to-back: held while busy
        while (fr_mon != n + 1) @(negedge clk);
        check(busy == 1'b1 && req_ready == 1'b0, "R2 held during quiet", {busy, req_ready}, 2);
      end
    end
    req_valid = 1'b0;
    while (fr_mon != NFR) @(negedge clk);
    repeat (QUIET + 2) @(negedge clk);
    check(busy == 1'b0 && req_ready == 1'b1, "R10 idle after quiet", {busy, req_ready}, 1);
    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule